// File: doc/BRIEF.md
# Segment Access Rights and Limit Checker

This block decides whether a single memory access may proceed through an already loaded segment descriptor. Each cycle it can take one request. A request carries the descriptor attribute flags, the descriptor's 20-bit raw limit, the 32-bit offset of the access, the access width and the kind of access: instruction fetch, data read or data write. One clock after the request strobe it returns a response. The response is a fault flag, a two-bit cause code, and the new value of the descriptor's accessed flag, which the surrounding logic writes back into the descriptor.

The check runs in a fixed order. First it confirms that the descriptor is present and that it describes a code or data segment. Next it tests whether the access kind is allowed for that segment type. Last it tests the access against the segment bounds. The limit is first scaled by the granularity flag. Data segments may grow upward or downward. For a downward-growing segment, the upper edge is set by the big flag.

Top module: `seg_access_check`

## Requirements
- R1: `rsp_valid` is high for exactly one cycle, in the cycle after each cycle in which `req_valid` is high. It is low otherwise. Between responses, `fault`, `cause` and `acc_out` hold their last values.
- R2: Cause codes are 0 for pass, 1 for not present or invalid type, 2 for rights violation and 3 for limit violation. `fault` is high exactly when the cause is non-zero. A descriptor with `desc_present`=0 or `desc_sys_n`=0 gives cause 1. The rights check takes precedence over the limit check.
- R3: With `desc_gran`=0 the effective limit is the raw limit, counted in bytes. With `desc_gran`=1 it is the raw limit shifted left by 12, with the 12 low bits set to ones.
- R4: `desc_exec`=1 marks a code segment. Access kinds are encoded as 0 for fetch, 1 for read, 2 for write and 3 for read. On a code segment a fetch is always allowed, a read is allowed only when `desc_rw`=1, and a write always gives cause 2.
- R5: `desc_exec`=0 marks a data segment. On a data segment a fetch gives cause 2, a read is allowed, and a write is allowed only when `desc_rw`=1.
- R6: Code segments, and data segments with `desc_dir`=0, pass the bound test only when the last byte of the access is at or below the effective limit. On a code segment `desc_dir` has no effect on the bound test.
- R7: A data segment with `desc_dir`=1 passes the bound test only when the first byte of the access is strictly above the effective limit.
- R8: For a data segment with `desc_dir`=1, the last byte must also be at or below FFFFh when `desc_big`=0, or at or below FFFFFFFFh when `desc_big`=1.
- R9: `size_sel` encodes the access width as 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. The last byte is `offset` + width − 1. If that sum carries out of 32 bits, the result is cause 3.
- R10: `acc_out` is 1 after a passing access. After a faulting access it equals the `desc_acc` that was presented with the request.
- R11: After reset, `rsp_valid`, `fault`, `cause` and `acc_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| desc_sys_n | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| desc_exec | input | 1 | 1 = code segment, 0 = data segment |
| desc_rw | input | 1 | Readable flag on code segments, writable flag on data segments |
| desc_dir | input | 1 | Expand-down flag on data segments; no effect on code segments |
| desc_big | input | 1 | Upper-edge select for expand-down segments |
| desc_gran | input | 1 | Limit granularity: 0 = bytes, 1 = 4 KB units |
| desc_acc | input | 1 | Current accessed flag |
| desc_present | input | 1 | Present flag |
| raw_limit | input | 20 | Raw segment limit |
| offset | input | 32 | Offset of the first accessed byte |
| size_sel | input | 2 | Access width code |
| kind | input | 2 | Access kind code |
| rsp_valid | output | 1 | Response strobe |
| fault | output | 1 | Access refused |
| cause | output | 2 | Fault cause code |
| acc_out | output | 1 | Updated accessed flag |

## Verification
All state sits in one registered stage. Any fault in the scaling, type decoding or bound arithmetic therefore shows up in the `cause` and `acc_out` of the response that follows the offending request, one clock later. Errors at the edges are the hardest to see. They are reached by offsets exactly at the effective limit, one byte past it, across the 16-bit upper edge and across the 32-bit carry. A stuck response stage would show up as `rsp_valid` failing to fall, or as outputs changing without a strobe.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_READX = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_TYPE   = 2'd1,
    CAUSE_RIGHTS = 2'd2,
    CAUSE_LIMIT  = 2'd3
  } cause_e;

  typedef struct packed {
    logic   fault;
    cause_e cause;
    logic   acc;
  } verdict_t;

endpackage

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
  parameter int LIM_W      = 20,
  parameter int OFS_W      = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [LIM_W-1:0] raw_limit,
  input  logic             gran,
  output logic [OFS_W-1:0] eff_limit
);
  localparam int SCALED_W = LIM_W + PAGE_SHIFT;

  logic [SCALED_W-1:0] scaled;
  logic [OFS_W-1:0]    byte_lim;
  logic [OFS_W-1:0]    page_lim;

  assign scaled   = {raw_limit, {PAGE_SHIFT{1'b1}}};
  assign byte_lim = {{(OFS_W-LIM_W){1'b0}}, raw_limit};

  generate
    if (SCALED_W >= OFS_W) begin : g_trunc
      assign page_lim = scaled[OFS_W-1:0];
    end else begin : g_ext
      assign page_lim = {{(OFS_W-SCALED_W){1'b0}}, scaled};
    end
  endgenerate

  assign eff_limit = gran ? page_lim : byte_lim;
endmodule

// File: rtl/seg_rights_eval.sv
module seg_rights_eval
  import seg_chk_pkg::*;
(
  input  logic  is_code,
  input  logic  rw_flag,
  input  kind_e kind,
  output logic  rights_ok
);
  always_comb begin
    rights_ok = 1'b0;
    if (is_code) begin
      unique case (kind)
        KIND_FETCH:             rights_ok = 1'b1;
        KIND_READ, KIND_READX:  rights_ok = rw_flag;
        KIND_WRITE:             rights_ok = 1'b0;
        default:                rights_ok = 1'b0;
      endcase
    end else begin
      unique case (kind)
        KIND_FETCH:             rights_ok = 1'b0;
        KIND_READ, KIND_READX:  rights_ok = 1'b1;
        KIND_WRITE:             rights_ok = rw_flag;
        default:                rights_ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/seg_bound_eval.sv
module seg_bound_eval #(
  parameter int OFS_W   = 32,
  parameter int SMALL_W = 16
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size_sel,
  input  logic [OFS_W-1:0] eff_limit,
  input  logic             expand_down,
  input  logic             big,
  output logic             in_bounds
);
  localparam int SPAN_W = 3;
  localparam logic [OFS_W-1:0] SMALL_TOP = {{(OFS_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

  logic [SPAN_W-1:0] span;
  logic [OFS_W:0]    last_w;
  logic              carry;
  logic [OFS_W-1:0]  last_b;
  logic              up_ok;
  logic              down_ok;
  logic              top_ok;

  always_comb begin
    unique case (size_sel)
      2'd0:    span = 3'd0;
      2'd1:    span = 3'd1;
      default: span = 3'd3;
    endcase
  end

  assign last_w = {1'b0, offset} + {{(OFS_W+1-SPAN_W){1'b0}}, span};
  assign carry  = last_w[OFS_W];
  assign last_b = last_w[OFS_W-1:0];

  assign up_ok   = !carry && (last_b <= eff_limit);
  assign top_ok  = big ? 1'b1 : (last_b <= SMALL_TOP);
  assign down_ok = !carry && (offset > eff_limit) && top_ok;

  assign in_bounds = expand_down ? down_ok : up_ok;
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
#(
  parameter int LIM_W      = 20,
  parameter int OFS_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SMALL_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             desc_sys_n,
  input  logic             desc_exec,
  input  logic             desc_rw,
  input  logic             desc_dir,
  input  logic             desc_big,
  input  logic             desc_gran,
  input  logic             desc_acc,
  input  logic             desc_present,
  input  logic [LIM_W-1:0] raw_limit,
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size_sel,
  input  logic [1:0]       kind,
  output logic             rsp_valid,
  output logic             fault,
  output logic [1:0]       cause,
  output logic             acc_out
);
  logic [OFS_W-1:0] eff_limit;
  logic             rights_ok;
  logic             in_bounds;
  logic             expand_down;
  verdict_t         nxt;
  verdict_t         cur;

  seg_limit_scale #(
    .LIM_W(LIM_W), .OFS_W(OFS_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_scale (
    .raw_limit (raw_limit),
    .gran      (desc_gran),
    .eff_limit (eff_limit)
  );

  seg_rights_eval u_rights (
    .is_code   (desc_exec),
    .rw_flag   (desc_rw),
    .kind      (kind_e'(kind)),
    .rights_ok (rights_ok)
  );

  // Code segments always grow upward; the direction bit only matters for data.
  assign expand_down = desc_dir && !desc_exec;

  seg_bound_eval #(
    .OFS_W(OFS_W), .SMALL_W(SMALL_W)
  ) u_bound (
    .offset      (offset),
    .size_sel    (size_sel),
    .eff_limit   (eff_limit),
    .expand_down (expand_down),
    .big         (desc_big),
    .in_bounds   (in_bounds)
  );

  always_comb begin
    if (!desc_present || !desc_sys_n) nxt.cause = CAUSE_TYPE;
    else if (!rights_ok)              nxt.cause = CAUSE_RIGHTS;
    else if (!in_bounds)              nxt.cause = CAUSE_LIMIT;
    else                              nxt.cause = CAUSE_NONE;
    nxt.fault = (nxt.cause != CAUSE_NONE);
    nxt.acc   = nxt.fault ? desc_acc : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      cur       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) cur <= nxt;
    end
  end

  assign fault   = cur.fault;
  assign cause   = cur.cause;
  assign acc_out = cur.acc;
endmodule

// File: rtl/seg_access_check_sva.sv
module seg_access_check_sva #(
  parameter int LIM_W = 20,
  parameter int OFS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             desc_sys_n,
  input logic             desc_exec,
  input logic             desc_rw,
  input logic             desc_dir,
  input logic             desc_big,
  input logic             desc_gran,
  input logic             desc_acc,
  input logic             desc_present,
  input logic [LIM_W-1:0] raw_limit,
  input logic [OFS_W-1:0] offset,
  input logic [1:0]       size_sel,
  input logic [1:0]       kind,
  input logic             rsp_valid,
  input logic             fault,
  input logic [1:0]       cause,
  input logic             acc_out
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(cause) && $stable(acc_out));
  assert_type_fault_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!desc_present || !desc_sys_n)) |=> (cause == 2'd1));
  assert_code_write_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && desc_present && desc_sys_n && desc_exec && kind == 2'd2) |=> (cause == 2'd2));
  assert_data_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && desc_present && desc_sys_n && !desc_exec && kind == 2'd0) |=> (cause == 2'd2));
  assert_acc_set_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !fault) |-> acc_out);
endmodule

bind seg_access_check seg_access_check_sva #(.LIM_W(LIM_W), .OFS_W(OFS_W)) u_sva (.*);

// File: tb/sim_seg_access_check.sv
module sim_seg_access_check;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        desc_sys_n, desc_exec, desc_rw, desc_dir, desc_big, desc_gran, desc_acc, desc_present;
  logic [19:0] raw_limit;
  logic [31:0] offset;
  logic [1:0]  size_sel, kind;
  logic        rsp_valid, fault, acc_out;
  logic [1:0]  cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_access_check u0 (.*);

  typedef struct packed {
    logic s, e, rw, dir, big, gran, acc, p;
    logic [19:0] lim;
    logic [31:0] off;
    logic [1:0]  sz, kd, ec;
    logic        ea;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1,1,1,0,0,0,0,1,20'h1FF,  32'h100,      2,1,0,1}, // R4 R6 code read ok
    '{1,1,0,0,0,0,0,1,20'h1FF,  32'h100,      0,1,2,0}, // R4 R10 exec-only read
    '{1,1,0,0,0,0,0,1,20'h1FF,  32'h0,        2,0,0,1}, // R4 fetch ok
    '{1,1,1,0,0,0,0,1,20'h1FF,  32'h10,       0,2,2,0}, // R4 code write
    '{1,0,0,0,0,0,0,1,20'h1FF,  32'h10,       0,2,2,0}, // R5 read-only write
    '{1,0,1,0,0,0,0,1,20'h1FF,  32'h1FE,      1,2,0,1}, // R6 last byte at limit
    '{1,0,1,0,0,0,0,1,20'h1FF,  32'h1FE,      2,2,3,0}, // R6 R9 past limit
    '{1,0,1,0,0,0,0,1,20'h1FF,  32'h0,        0,0,2,0}, // R5 data fetch
    '{1,0,1,0,0,0,1,0,20'h1FF,  32'h0,        0,1,1,1}, // R2 R10 not present
    '{0,0,1,0,0,0,0,1,20'h1FF,  32'h0,        0,1,1,0}, // R2 system type
    '{1,0,0,0,0,0,0,1,20'h1FF,  32'h300,      0,2,2,0}, // R2 rights before limit
    '{1,0,0,0,0,1,0,1,20'h1,    32'h1FFF,     0,1,0,1}, // R3 page scale top byte
    '{1,0,0,0,0,1,0,1,20'h1,    32'h1FFE,     2,1,3,0}, // R3 page scale over
    '{1,0,0,0,0,0,0,1,20'h1,    32'h1FFF,     0,1,3,0}, // R3 byte scale over
    '{1,0,1,1,1,0,0,1,20'hFFF,  32'h1000,     2,2,0,1}, // R7 just above limit
    '{1,0,1,1,1,0,1,1,20'hFFF,  32'hFFF,      0,1,3,1}, // R7 R10 at limit faults
    '{1,0,1,1,0,0,0,1,20'hFFF,  32'hFFFE,     1,1,0,1}, // R8 small top reached
    '{1,0,1,1,0,0,0,1,20'hFFF,  32'hFFFE,     2,1,3,0}, // R8 small top crossed
    '{1,0,1,1,1,0,0,1,20'hFFF,  32'hFFFFFFFE, 1,1,0,1}, // R8 big top reached
    '{1,0,1,1,1,0,0,1,20'hFFF,  32'hFFFFFFFE, 2,1,3,0}, // R9 carry expand-down
    '{1,0,0,0,0,1,0,1,20'hFFFFF,32'hFFFFFFFF, 0,1,0,1}, // R3 full range
    '{1,0,0,0,0,1,0,1,20'hFFFFF,32'hFFFFFFFF, 1,1,3,0}, // R9 carry expand-up
    '{1,0,1,0,0,0,0,1,20'h1FF,  32'h1FD,      3,1,3,0}, // R9 size 3 is 4 bytes
    '{1,1,0,0,0,0,0,1,20'h1FF,  32'h0,        0,3,2,0}, // R4 kind 3 is read
    '{1,1,1,1,0,0,0,1,20'h1FF,  32'h100,      0,1,0,1}, // R6 dir ignored on code
    '{1,0,1,1,1,1,0,1,20'hF,    32'h10000,    0,1,0,1}, // R3 R7 scaled down limit
    '{1,0,1,1,0,0,0,1,20'hFFF,  32'h10000,    0,1,3,0}  // R8 above small top
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    {desc_sys_n, desc_exec, desc_rw, desc_dir, desc_big, desc_gran, desc_acc, desc_present}
      = {v.s, v.e, v.rw, v.dir, v.big, v.gran, v.acc, v.p};
    raw_limit = v.lim;
    offset    = v.off;
    size_sel  = v.sz;
    kind      = v.kd;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid", 32'(rsp_valid), 0);
    check("R11 fault", 32'(fault), 0);
    check("R11 cause", 32'(cause), 0);
    check("R11 acc_out", 32'(acc_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle valid", 32'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R1 vec%0d valid", i), 32'(rsp_valid), 1);
      check($sformatf("vec%0d cause", i), 32'(cause), 32'(VEC[i].ec));
      check($sformatf("R2 vec%0d fault", i), 32'(fault), 32'(VEC[i].ec != 2'd0));
      check($sformatf("R10 vec%0d acc", i), 32'(acc_out), 32'(VEC[i].ea));
    end

    // R1: no strobe -> valid drops, outputs hold despite new inputs
    drive(VEC[1]);
    @(negedge clk);
    check("R1 valid drops", 32'(rsp_valid), 0);
    check("R1 cause held", 32'(cause), 32'(VEC[NV-1].ec));
    check("R1 acc held", 32'(acc_out), 32'(VEC[NV-1].ea));

    // R1 back-to-back strobes
    drive(VEC[0]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first", 32'(cause), 0);
    drive(VEC[3]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 b2b valid", 32'(rsp_valid), 1);
    check("R4 b2b second", 32'(cause), 2);

    // R11 reset mid-run clears a faulting response
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 cause after reset", 32'(cause), 0);
    check("R11 valid after reset", 32'(rsp_valid), 0);

    finish_run();
  end
endmodule